// File: doc/BRIEF.md
# Shifted-Operand Recompute ALU

This block is a small arithmetic and logic unit with its own error detection. It can add, AND, OR or XOR two W-bit operands. Every accepted request runs twice through the same bit-sliced datapath. The first pass uses the operands as given, and its result is kept in a holding register. The second pass shifts both operands up by two bit positions. It also moves the carry-in up to bit 2 and fills the two freed low bits with zeros. The second-pass result is shifted back down by two and compared with the held value.

The datapath is W+2 slices wide, so the shifted operands lose no bits. In the first pass a given slice works on a different bit of the answer than it does in the second pass. A slice that is wrong in one pass therefore shows up as a mismatch. On completion the block gives the first-pass result, a one-cycle done strobe and an error flag. A test-only port can force the sum output of one chosen slice to a constant.

Top module: `shiftcheck_alu`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, done, err, busy, cout and result are all zero until the first request completes.
- R2: When start is high at a rising edge and busy is low, the request is accepted. busy is high for the next two cycles. done is high for exactly one cycle, two rising edges after the accepting edge, and busy is low in that cycle.
- R3: A start pulse while busy is high is ignored: it produces no extra done and does not change the operands of the request in progress.
- R4: With op = 2'b00 (add), result = (a + b + cin) mod 2^W and cout is the carry out of bit W-1.
- R5: With op = 2'b01, 2'b10 and 2'b11, result is a AND b, a OR b and a XOR b respectively. cout is 0 and cin has no effect.
- R6: With flt_en low during both passes, err is 0 at done.
- R7: With flt_en high and flt_sel = i < W, slice i drives flt_val as result bit i in pass one. If that differs from the true bit i, result shows flt_val at bit i and err is 1.
- R8: With flt_sel = i >= 2, slice i computes true bit i-2 in pass two. If flt_val differs from that bit, err is 1. A fault in slice W or W+1 never alters result.
- R9: A forced value that equals every true bit the selected slice produces in both passes leaves err at 0 and result correct.
- R10: result, cout and err hold their values from one done until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken when busy is low |
| op | input | 2 | 00 add, 01 AND, 10 OR, 11 XOR |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry-in for add |
| flt_en | input | 1 | Test only: enable sum forcing |
| flt_sel | input | SEL_W | Test only: slice index 0..W+1 to force |
| flt_val | input | 1 | Test only: forced sum value |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | W | First-pass result |
| cout | output | 1 | First-pass carry-out (0 for logic ops) |
| err | output | 1 | Passes disagreed |

## Verification
The hardest cases to reach are those where a faulty slice corrupts only one of the two passes, or neither. A fault in the two top slices touches pass two only. A fault whose forced value happens to match the true bit leaves the answer unchanged. The bench holds the fault port steady across a request and picks the operands so that the selected slice's true bits in each pass are known. It sweeps every slice index with both forced values over several operand patterns. This yields cases that flag in pass one only, in pass two only, in both, or in neither.

// File: rtl/shiftcheck_alu.sv
module shiftcheck_alu #(
  parameter int W     = 8,
  parameter int SEL_W = $clog2(W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             cin,
  input  logic             flt_en,
  input  logic [SEL_W-1:0] flt_sel,
  input  logic             flt_val,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     result,
  output logic             cout,
  output logic             err
);
  localparam int D = W + 2;
  localparam logic [1:0] OP_ADD = 2'b00, OP_AND = 2'b01, OP_OR = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_P1, S_P2} state_t;
  state_t st;

  logic [W-1:0] a_q, b_q, r1_q;
  logic [1:0]   op_q;
  logic         cin_q, c1_q, saw_flt;

  logic         p2;
  logic [D-1:0] xa, xb, s;
  logic [D:0]   c;
  logic         is_add, cout_p1, cout_p2, mismatch;

  assign p2     = (st == S_P2);
  assign is_add = (op_q == OP_ADD);
  assign xa     = p2 ? {a_q, 2'b00} : {2'b00, a_q};
  assign xb     = p2 ? {b_q, 2'b00} : {2'b00, b_q};
  assign c[0]   = ~p2 & cin_q;

  for (genvar i = 0; i < D; i++) begin : g_slice
    logic ci, t;
    if (i == 2) begin : g_cin2
      assign ci = c[i] | (p2 & cin_q);
    end else begin : g_cin
      assign ci = c[i];
    end
    assign t = is_add           ? (xa[i] ^ xb[i] ^ ci) :
               (op_q == OP_AND) ? (xa[i] & xb[i]) :
               (op_q == OP_OR)  ? (xa[i] | xb[i]) : (xa[i] ^ xb[i]);
    assign s[i]   = (flt_en && flt_sel == SEL_W'(i)) ? flt_val : t;
    assign c[i+1] = (xa[i] & xb[i]) | (ci & (xa[i] ^ xb[i]));
  end

  assign cout_p1  = is_add & c[W];
  assign cout_p2  = is_add & c[D];
  assign mismatch = {c1_q, r1_q} != {cout_p2, s[D-1:2]};
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; a_q <= '0; b_q <= '0; op_q <= '0; cin_q <= 1'b0;
      r1_q <= '0; c1_q <= 1'b0; saw_flt <= 1'b0;
      result <= '0; cout <= 1'b0; err <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          a_q <= a; b_q <= b; op_q <= op; cin_q <= cin;
          st <= S_P1;
        end
        S_P1: begin
          r1_q    <= s[W-1:0];
          c1_q    <= cout_p1;
          saw_flt <= flt_en;
          st      <= S_P2;
        end
        S_P2: begin
          result  <= r1_q;
          cout    <= c1_q;
          err     <= mismatch;
          saw_flt <= saw_flt | flt_en;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_logic_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q != OP_ADD) |-> !cout);
  assert_clean_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !saw_flt) |-> !err);
  assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !p2 |=> ($stable(result) && $stable(cout) && $stable(err)));
endmodule

// File: tb/shiftcheck_alu_tb_top.sv
module shiftcheck_alu_tb_top;
  localparam int W = 8;
  localparam int SW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cin = 1'b0;
  logic flt_en = 1'b0, flt_val = 1'b0;
  logic [SW-1:0] flt_sel = '0;
  logic [1:0] op = '0;
  logic [W-1:0] a = '0, b = '0;
  logic busy, done, cout, err;
  logic [W-1:0] result;

  always #5 clk = ~clk;

  shiftcheck_alu #(.W(W), .SEL_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b), .cin(cin),
    .flt_en(flt_en), .flt_sel(flt_sel), .flt_val(flt_val),
    .busy(busy), .done(done), .result(result), .cout(cout), .err(err));

  typedef struct packed { logic [W-1:0] r; logic c; logic e; } exp_t;
  exp_t  sb_q[$];
  string tag_q[$];
  int checks = 0, fails = 0, dones = 0, pushed = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] x, input logic [W-1:0] y, input logic [1:0] o,
                                 input logic ci, input logic fe, input logic [SW-1:0] fs, input logic fv);
    exp_t m;
    logic [W:0] full;
    logic p1w, p2w;
    case (o)
      2'b00: full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
      2'b01: full = {1'b0, x & y};
      2'b10: full = {1'b0, x | y};
      default: full = {1'b0, x ^ y};
    endcase
    m.r = full[W-1:0];
    m.c = full[W];
    p1w = fe && (int'(fs) < W) && (full[fs] != fv);
    p2w = fe && (int'(fs) >= 2) && (full[fs-2] != fv);
    if (fe && int'(fs) < W) m.r[fs] = fv;
    m.e = p1w | p2w;
    return m;
  endfunction

  // Monitor: pops expected items as done strobes appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      dones++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R3 unexpected done", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check(result == e.r, {t, " result"}, result, e.r);
        check(cout == e.c, {t, " cout"}, cout, e.c);
        check(err == e.e, {t, " err"}, err, e.e);
      end
    end
  end

  task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input logic [1:0] o,
                        input logic ci, input logic fe, input logic [SW-1:0] fs, input logic fv,
                        input string tag, input bit poke);
    sb_q.push_back(model(x, y, o, ci, fe, fs, fv));
    tag_q.push_back(tag);
    pushed++;
    a = x; b = y; op = o; cin = ci; flt_en = fe; flt_sel = fs; flt_val = fv; start = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (poke) begin
        start = 1'b1; a = ~x; b = x ^ y; op = o + 2'd1; cin = ~ci;
      end else start = 1'b0;
      check(busy && !done, "R2 busy window", {busy, done}, 2'b10);
    end
    @(negedge clk);
    start = 1'b0;
    check(done && !busy, "R2 done timing", {busy, done}, 2'b01);
    flt_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] x, y;
    logic [31:0] lcg;
    lcg = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check({done, err, busy, cout, result} == '0, "R1 reset outputs", {done, err, busy, cout, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({done, err, busy, cout, result} == '0, "R1 after release", {done, err, busy, cout, result}, 0);

    run_op(8'hFF, 8'h01, 2'b00, 1'b0, 1'b0, '0, 1'b0, "R4 add wrap", 0);
    run_op(8'hFF, 8'hFF, 2'b00, 1'b1, 1'b0, '0, 1'b0, "R4 add cin full", 0);
    run_op(8'h3C, 8'h0F, 2'b00, 1'b1, 1'b0, '0, 1'b0, "R4 add cin", 0);
    run_op(8'hA5, 8'h3C, 2'b01, 1'b1, 1'b0, '0, 1'b0, "R5 and", 0);
    run_op(8'hA5, 8'h3C, 2'b10, 1'b1, 1'b0, '0, 1'b0, "R5 or", 0);
    run_op(8'hA5, 8'h3C, 2'b11, 1'b0, 1'b0, '0, 1'b0, "R5 xor", 0);
    for (int n = 0; n < 16; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      run_op(lcg[7:0], lcg[15:8], lcg[17:16], lcg[20], 1'b0, '0, 1'b0, "R6 clean sweep", 0);
    end

    for (int p = 0; p < 4; p++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      x = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : lcg[7:0];
      y = (p == 0) ? 8'h00 : (p == 1) ? 8'h00 : lcg[15:8];
      for (int s = 0; s < W + 2; s++)
        for (int v = 0; v < 2; v++)
          run_op(x, y, p[1:0], lcg[24], 1'b1, SW'(s), v[0],
                 (s >= W) ? "R8 high slice fault" : (p < 2 ? "R9 R7 fault" : "R7 fault"), 0);
    end
    run_op(8'h00, 8'h00, 2'b01, 1'b0, 1'b1, 4'd9, 1'b0, "R9 matching upper fault", 0);
    run_op(8'h00, 8'h00, 2'b00, 1'b0, 1'b1, 4'd9, 1'b1, "R8 upper fault flags", 0);

    run_op(8'h12, 8'h34, 2'b00, 1'b0, 1'b0, '0, 1'b0, "R3 poke during busy", 1);
    repeat (5) @(negedge clk);
    check(result == 8'h46 && !err && !cout, "R10 hold", result, 8'h46);
    check(dones == pushed && sb_q.size() == 0, "R3 done count", dones, pushed);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule